// File: doc/BRIEF.md
# DMA Transfer Submission Queue

This block is the register-mapped front end of a single-channel DMA engine. Software fills a set of staging registers with one transfer (destination and source address, X and Y length, the two strides and three flag bits) and then writes the start register. The staged contents, tagged with a hardware-allocated transfer ID, go into a small descriptor queue. The head of the queue is offered to the data mover over a valid/ready stream. The mover takes a descriptor when `desc_valid` and `desc_ready` are both high on a clock edge. While `desc_ready` is low the head is held unchanged. While the channel is paused or disabled, `desc_valid` stays low.

The mover reports each finished transfer with a one-cycle `done_valid` strobe that carries the ID. The block keeps a completion bitmap indexed by ID. It raises a start interrupt when the mover accepts a descriptor, which frees a queue slot, and an end interrupt when a completion arrives. Features are chosen by parameters. Software finds out which ones exist by writing a register and reading the value back.

Top module: `dma_submit_queue`

## Requirements
- R1: After reset, `irq` and `desc_valid` are 0. The next-ID register (0x404), start register (0x408) and completion register (0x428) read 0, and the interrupt mask (0x80) reads 3.
- R2: Writing a value with bit 0 set to 0x408, while enabled and not full, queues the staged registers tagged with the ID read from 0x404. That ID then advances by one and wraps to 0 after NUM_IDS-1.
- R3: 0x408 reads 1 exactly when DEPTH descriptors are waiting. A start write while full is dropped and consumes no ID.
- R4: The queue head is presented in submission order and is held stable while `desc_valid` is high and `desc_ready` is low. When the pause bit (bit 1 of control register 0x400) is set, `desc_valid` is 0.
- R5: Pending register 0x84 gets bit 0 (start) set one cycle after a descriptor handshake, and bit 1 (end) set one cycle after `done_valid`. Writing ones to 0x84 clears those bits, but a new event in the same cycle wins over the clear.
- R6: `irq` is the OR of the pending bits whose mask bit (0x80) is 0. Register 0x88 reads the pending value ANDed with the inverted mask.
- R7: `done_valid` sets bit `done_id` of 0x428. The bit stays set until that ID is handed out again by a submission, which clears it. Bit 31 reads 0.
- R8: Writing 0x400 with bit 0 (enable) clear empties the queue, so `desc_valid` is 0 and 0x408 reads 0 afterwards. Start writes while disabled are ignored.
- R9: Feature probing works as follows. Flags (0x40C, bit 0 cyclic, bit 1 last, bit 2 partial report) drop bit 0 without cyclic support. Y length (0x41C) reads 0 without 2D support. Destination address and stride (0x410, 0x420) read 0 without a memory-side destination, and source address and stride (0x414, 0x424) read 0 without a memory-side source.
- R10: X length (0x418) keeps only its low LEN_W bits and reads back with its LEN_ALIGN_BITS low bits forced to 1, so writing 0 returns the alignment mask.
- R11: Register 0x42C reads the ID of the descriptor most recently accepted by the mover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt request |
| eng_enable | output | 1 | Channel enable |
| eng_pause | output | 1 | Channel pause |
| desc_valid | output | 1 | Queue head is offered |
| desc_ready | input | 1 | Mover accepts the head |
| desc_id | output | 5 | Transfer ID of the head |
| desc_flags | output | 3 | Flags of the head |
| desc_dst | output | 32 | Destination address |
| desc_src | output | 32 | Source address |
| desc_xlen | output | 32 | X length as read back |
| desc_ylen | output | 32 | Y length |
| desc_dst_stride | output | 32 | Destination stride |
| desc_src_stride | output | 32 | Source stride |
| done_valid | input | 1 | Completion strobe |
| done_id | input | 5 | ID of the completed transfer |

## Verification
The submission path is driven with back-pressure held off until the queue fills, then with single-cycle accepts, and finally with `desc_ready` held high. These three patterns separate the full flag and dropped starts from ordering and stalls, and the held-high case exercises steady flow across an ID wrap. Staging registers are probed on two configurations that share one bus: a fully featured instance and one without cyclic, 2D or memory-side destination support. The same writes must then produce different readback values. Interrupts are checked with the mask both set and cleared, so pending state and the request line are told apart.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
  localparam logic [11:0] OFS_IRQ_MASK = 12'h080;
  localparam logic [11:0] OFS_IRQ_PEND = 12'h084;
  localparam logic [11:0] OFS_IRQ_SRC  = 12'h088;
  localparam logic [11:0] OFS_CTRL     = 12'h400;
  localparam logic [11:0] OFS_NEXT_ID  = 12'h404;
  localparam logic [11:0] OFS_START    = 12'h408;
  localparam logic [11:0] OFS_FLAGS    = 12'h40C;
  localparam logic [11:0] OFS_DST      = 12'h410;
  localparam logic [11:0] OFS_SRC      = 12'h414;
  localparam logic [11:0] OFS_XLEN     = 12'h418;
  localparam logic [11:0] OFS_YLEN     = 12'h41C;
  localparam logic [11:0] OFS_DSTRIDE  = 12'h420;
  localparam logic [11:0] OFS_SSTRIDE  = 12'h424;
  localparam logic [11:0] OFS_DONE     = 12'h428;
  localparam logic [11:0] OFS_ACT_ID   = 12'h42C;

  typedef struct packed {
    logic [4:0]  id;
    logic [2:0]  flags;
    logic [31:0] dst;
    logic [31:0] src;
    logic [31:0] xlen;
    logic [31:0] ylen;
    logic [31:0] dst_stride;
    logic [31:0] src_stride;
  } xfer_desc_t;
endpackage

// File: rtl/dsq_fifo.sv
module dsq_fifo #(
  parameter int DEPTH = 4,
  parameter type T = logic
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic push,
  input  T     push_data,
  input  logic pop,
  output T     head,
  output logic empty,
  output logic full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  T mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == FULL_CNT);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      if (do_push && !do_pop) count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= push_data;
  end
endmodule

// File: rtl/dsq_ids.sv
module dsq_ids #(
  parameter int NUM_IDS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        alloc,
  input  logic        done_valid,
  input  logic [4:0]  done_id,
  output logic [4:0]  next_id,
  output logic [31:0] done_map
);
  localparam logic [4:0] ID_LAST = 5'(NUM_IDS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) next_id <= '0;
    else if (alloc) next_id <= (next_id == ID_LAST) ? '0 : next_id + 1'b1;
  end

  for (genvar g = 0; g < 32; g++) begin : g_bit
    if (g < NUM_IDS && g < 31) begin : g_live
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done_map[g] <= 1'b0;
        else if (done_valid && done_id == 5'(g)) done_map[g] <= 1'b1;
        else if (alloc && next_id == 5'(g)) done_map[g] <= 1'b0;
      end
    end else begin : g_dead
      assign done_map[g] = 1'b0;
    end
  end
endmodule

// File: rtl/dsq_irq.sv
module dsq_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sot_evt,
  input  logic       eot_evt,
  input  logic       clr_wr,
  input  logic [1:0] clr_bits,
  input  logic       mask_wr,
  input  logic [1:0] mask_bits,
  output logic [1:0] pend,
  output logic [1:0] mask,
  output logic       irq
);
  logic [1:0] set_bits;
  assign set_bits = {eot_evt, sot_evt};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      mask <= 2'b11;
    end else begin
      pend <= (pend & ~(clr_wr ? clr_bits : 2'b00)) | set_bits;
      if (mask_wr) mask <= mask_bits;
    end
  end

  assign irq = |(pend & ~mask);
endmodule

// File: rtl/dma_submit_queue.sv
module dma_submit_queue #(
  parameter int ADDR_W         = 12,
  parameter int DEPTH          = 4,
  parameter int NUM_IDS        = 16,
  parameter int LEN_W          = 24,
  parameter int LEN_ALIGN_BITS = 2,
  parameter bit HAS_CYCLIC     = 1'b1,
  parameter bit HAS_2D         = 1'b1,
  parameter bit HAS_DST_MEM    = 1'b1,
  parameter bit HAS_SRC_MEM    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              eng_enable,
  output logic              eng_pause,
  output logic              desc_valid,
  input  logic              desc_ready,
  output logic [4:0]        desc_id,
  output logic [2:0]        desc_flags,
  output logic [31:0]       desc_dst,
  output logic [31:0]       desc_src,
  output logic [31:0]       desc_xlen,
  output logic [31:0]       desc_ylen,
  output logic [31:0]       desc_dst_stride,
  output logic [31:0]       desc_src_stride,
  input  logic              done_valid,
  input  logic [4:0]        done_id
);
  import dsq_pkg::*;

  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [31:0] LEN_MASK   = 32'((64'd1 << LEN_W) - 64'd1);
  localparam logic [31:0] ALIGN_MASK = 32'((64'd1 << LEN_ALIGN_BITS) - 64'd1);
  localparam logic [2:0]  FLAG_KEEP  = {2'b11, HAS_CYCLIC};
  localparam logic [31:0] DST_KEEP   = {32{HAS_DST_MEM}};
  localparam logic [31:0] SRC_KEEP   = {32{HAS_SRC_MEM}};
  localparam logic [31:0] Y_KEEP     = HAS_2D ? LEN_MASK : 32'd0;

  logic [1:0]  ctrl_q;
  logic [2:0]  flags_q;
  logic [31:0] dst_q, src_q, xlen_q, ylen_q, dstride_q, sstride_q;
  logic [4:0]  act_id_q;

  logic [11:0] ofs;
  logic        wr_ctrl, wr_start, q_push, q_pop, q_flush, q_empty, q_full;
  logic [CNT_W-1:0] q_count;
  logic [4:0]  next_id;
  logic [31:0] done_map, xlen_rd;
  logic [1:0]  irq_pend, irq_mask;
  xfer_desc_t  staged, head;

  assign ofs      = 12'(reg_addr);
  assign wr_ctrl  = reg_wr_en && ofs == OFS_CTRL;
  assign wr_start = reg_wr_en && ofs == OFS_START && reg_wdata[0];
  assign q_flush  = wr_ctrl && !reg_wdata[0];
  assign q_push   = wr_start && ctrl_q[0] && !q_full;
  assign xlen_rd  = xlen_q | ALIGN_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      flags_q   <= '0;
      dst_q     <= '0;
      src_q     <= '0;
      xlen_q    <= '0;
      ylen_q    <= '0;
      dstride_q <= '0;
      sstride_q <= '0;
    end else if (reg_wr_en) begin
      unique case (ofs)
        OFS_CTRL:    ctrl_q    <= reg_wdata[1:0];
        OFS_FLAGS:   flags_q   <= reg_wdata[2:0] & FLAG_KEEP;
        OFS_DST:     dst_q     <= reg_wdata & DST_KEEP;
        OFS_SRC:     src_q     <= reg_wdata & SRC_KEEP;
        OFS_XLEN:    xlen_q    <= reg_wdata & LEN_MASK;
        OFS_YLEN:    ylen_q    <= reg_wdata & Y_KEEP;
        OFS_DSTRIDE: dstride_q <= reg_wdata & DST_KEEP;
        OFS_SSTRIDE: sstride_q <= reg_wdata & SRC_KEEP;
        default: ;
      endcase
    end
  end

  always_comb begin
    staged.id         = next_id;
    staged.flags      = flags_q;
    staged.dst        = dst_q;
    staged.src        = src_q;
    staged.xlen       = xlen_rd;
    staged.ylen       = ylen_q;
    staged.dst_stride = dstride_q;
    staged.src_stride = sstride_q;
  end

  dsq_fifo #(.DEPTH(DEPTH), .T(xfer_desc_t)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(q_flush), .push(q_push),
    .push_data(staged), .pop(q_pop), .head(head), .empty(q_empty),
    .full(q_full), .count(q_count)
  );

  dsq_ids #(.NUM_IDS(NUM_IDS)) u_ids (
    .clk(clk), .rst_n(rst_n), .alloc(q_push), .done_valid(done_valid),
    .done_id(done_id), .next_id(next_id), .done_map(done_map)
  );

  dsq_irq u_irq (
    .clk(clk), .rst_n(rst_n), .sot_evt(q_pop), .eot_evt(done_valid),
    .clr_wr(reg_wr_en && ofs == OFS_IRQ_PEND), .clr_bits(reg_wdata[1:0]),
    .mask_wr(reg_wr_en && ofs == OFS_IRQ_MASK), .mask_bits(reg_wdata[1:0]),
    .pend(irq_pend), .mask(irq_mask), .irq(irq)
  );

  assign eng_enable = ctrl_q[0];
  assign eng_pause  = ctrl_q[1];
  assign desc_valid = !q_empty && ctrl_q[0] && !ctrl_q[1];
  assign q_pop      = desc_valid && desc_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_id_q <= '0;
    else if (q_pop) act_id_q <= head.id;
  end

  assign desc_id         = head.id;
  assign desc_flags      = head.flags;
  assign desc_dst        = head.dst;
  assign desc_src        = head.src;
  assign desc_xlen       = head.xlen;
  assign desc_ylen       = head.ylen;
  assign desc_dst_stride = head.dst_stride;
  assign desc_src_stride = head.src_stride;

  always_comb begin
    reg_rdata = '0;
    unique case (ofs)
      OFS_IRQ_MASK: reg_rdata = {30'd0, irq_mask};
      OFS_IRQ_PEND: reg_rdata = {30'd0, irq_pend};
      OFS_IRQ_SRC:  reg_rdata = {30'd0, irq_pend & ~irq_mask};
      OFS_CTRL:     reg_rdata = {30'd0, ctrl_q};
      OFS_NEXT_ID:  reg_rdata = {27'd0, next_id};
      OFS_START:    reg_rdata = {31'd0, q_full};
      OFS_FLAGS:    reg_rdata = {29'd0, flags_q};
      OFS_DST:      reg_rdata = dst_q;
      OFS_SRC:      reg_rdata = src_q;
      OFS_XLEN:     reg_rdata = xlen_rd;
      OFS_YLEN:     reg_rdata = ylen_q;
      OFS_DSTRIDE:  reg_rdata = dstride_q;
      OFS_SSTRIDE:  reg_rdata = sstride_q;
      OFS_DONE:     reg_rdata = done_map;
      OFS_ACT_ID:   reg_rdata = {27'd0, act_id_q};
      default:      reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dsq_checker.sv
module dsq_checker #(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              wbit0,
  input logic              desc_valid,
  input logic              desc_ready,
  input logic [4:0]        desc_id,
  input logic              eng_pause,
  input logic              done_valid,
  input logic              irq,
  input logic [1:0]        pend,
  input logic [$clog2(DEPTH+1)-1:0] q_count
);
  // R4
  hold_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && !desc_ready && !reg_wr_en |=> desc_valid && $stable(desc_id));
  // R4
  pause_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_pause |-> !desc_valid);
  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= ($clog2(DEPTH+1))'(DEPTH));
  // R5
  eot_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> pend[1]);
  // R5
  sot_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && desc_ready |=> pend[0]);
  // R6
  quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend == 2'b00 |-> !irq);
  // R8
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en && 12'(reg_addr) == dsq_pkg::OFS_CTRL && !wbit0 |=> q_count == '0 && !desc_valid);
endmodule

bind dma_submit_queue dsq_checker #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
  .wbit0(reg_wdata[0]), .desc_valid(desc_valid), .desc_ready(desc_ready),
  .desc_id(desc_id), .eng_pause(eng_pause), .done_valid(done_valid),
  .irq(irq), .pend(irq_pend), .q_count(q_count)
);

// File: tb/test_dma_submit_queue.sv
`timescale 1ns/1ps
module test_dma_submit_queue;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic desc_ready = 1'b0;
  logic done_valid = 1'b0;
  logic [4:0] done_id = '0;

  logic [31:0] rdata, rdata_b;
  logic irq, en, pause, dvalid, irq_b, en_b, pause_b, dvalid_b;
  logic [4:0] did, did_b;
  logic [2:0] dfl, dfl_b;
  logic [31:0] ddst, dsrc, dx, dy, dds, dss;
  logic [31:0] ddst_b, dsrc_b, dx_b, dy_b, dds_b, dss_b;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dma_submit_queue i_dma_submit_queue (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata), .irq(irq), .eng_enable(en),
    .eng_pause(pause), .desc_valid(dvalid), .desc_ready(desc_ready),
    .desc_id(did), .desc_flags(dfl), .desc_dst(ddst), .desc_src(dsrc),
    .desc_xlen(dx), .desc_ylen(dy), .desc_dst_stride(dds), .desc_src_stride(dss),
    .done_valid(done_valid), .done_id(done_id)
  );

  dma_submit_queue #(.LEN_ALIGN_BITS(0), .HAS_CYCLIC(1'b0), .HAS_2D(1'b0),
                     .HAS_DST_MEM(1'b0)) i_dma_submit_queue_bare (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_b), .irq(irq_b), .eng_enable(en_b),
    .eng_pause(pause_b), .desc_valid(dvalid_b), .desc_ready(desc_ready),
    .desc_id(did_b), .desc_flags(dfl_b), .desc_dst(ddst_b), .desc_src(dsrc_b),
    .desc_xlen(dx_b), .desc_ylen(dy_b), .desc_dst_stride(dds_b),
    .desc_src_stride(dss_b), .done_valid(done_valid), .done_id(done_id)
  );

  // {offset, write value, readback full config, readback reduced config}
  localparam logic [127:0] VEC [10] = '{
    {32'h418, 32'h0000_0000, 32'h0000_0003, 32'h0000_0000},  // R10
    {32'h418, 32'h0000_0100, 32'h0000_0103, 32'h0000_0100},  // R10
    {32'h418, 32'hFFFF_FFFF, 32'h00FF_FFFF, 32'h00FF_FFFF},  // R10
    {32'h41C, 32'h0000_0009, 32'h0000_0009, 32'h0000_0000},  // R9
    {32'h40C, 32'h0000_0007, 32'h0000_0007, 32'h0000_0006},  // R9
    {32'h40C, 32'h0000_0001, 32'h0000_0001, 32'h0000_0000},  // R9
    {32'h410, 32'h1000_0040, 32'h1000_0040, 32'h0000_0000},  // R9
    {32'h414, 32'h2000_0080, 32'h2000_0080, 32'h2000_0080},  // R9
    {32'h420, 32'h0000_0400, 32'h0000_0400, 32'h0000_0000},  // R9
    {32'h424, 32'h0000_0200, 32'h0000_0200, 32'h0000_0200}   // R9
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v, output logic [31:0] vb);
    @(negedge clk);
    reg_addr = a;
    #1;
    v = rdata; vb = rdata_b;
  endtask

  task automatic accept_one();
    @(negedge clk); desc_ready = 1'b1;
    @(negedge clk); desc_ready = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, vb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1;
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 desc_valid", {31'd0, dvalid}, 32'd0);
    rd(12'h404, v, vb); chk("R1 next id", v, 32'd0);
    rd(12'h408, v, vb); chk("R1 start", v, 32'd0);
    rd(12'h428, v, vb); chk("R1 done", v, 32'd0);
    rd(12'h080, v, vb); chk("R1 mask", v, 32'd3);

    // R9 / R10 feature vectors on both configurations
    for (int i = 0; i < 10; i++) begin
      wr(VEC[i][107:96], VEC[i][95:64]);
      rd(VEC[i][107:96], v, vb);
      chk("R9/R10 full cfg", v, VEC[i][63:32]);
      chk("R9/R10 reduced cfg", vb, VEC[i][31:0]);
    end

    // R2 / R3 fill the queue
    wr(12'h400, 32'd1);
    wr(12'h418, 32'h40);
    for (int k = 1; k <= 4; k++) begin
      wr(12'h410, 32'h100 * k);
      wr(12'h408, 32'd1);
    end
    rd(12'h404, v, vb); chk("R2 next id after 4", v, 32'd4);
    rd(12'h408, v, vb); chk("R3 full reads 1", v, 32'd1);
    wr(12'h410, 32'h500);
    wr(12'h408, 32'd1);
    rd(12'h404, v, vb); chk("R3 drop when full keeps id", v, 32'd4);
    chk("R4 head id", {27'd0, did}, 32'd0);
    chk("R4 head dst", ddst, 32'h100);
    chk("R2 head xlen", dx, 32'h43);
    chk("R4 valid", {31'd0, dvalid}, 32'd1);

    // R4 / R5 / R6 / R11 one accept
    accept_one();
    chk("R4 order id", {27'd0, did}, 32'd1);
    chk("R4 order dst", ddst, 32'h200);
    rd(12'h408, v, vb); chk("R3 not full", v, 32'd0);
    rd(12'h42C, v, vb); chk("R11 active id", v, 32'd0);
    rd(12'h084, v, vb); chk("R5 sot pending", v, 32'd1);
    chk("R6 masked irq", {31'd0, irq}, 32'd0);
    wr(12'h080, 32'd0);
    #1 chk("R6 irq unmasked", {31'd0, irq}, 32'd1);
    rd(12'h088, v, vb); chk("R6 source", v, 32'd1);
    wr(12'h084, 32'd1);
    rd(12'h084, v, vb); chk("R5 clear", v, 32'd0);
    #1 chk("R6 irq cleared", {31'd0, irq}, 32'd0);

    // R4 pause
    wr(12'h400, 32'd3);
    #1 chk("R4 pause blocks", {31'd0, dvalid}, 32'd0);
    wr(12'h400, 32'd1);
    #1 chk("R4 resume", {31'd0, dvalid}, 32'd1);
    accept_one();
    rd(12'h42C, v, vb); chk("R11 active id next", v, 32'd1);
    wr(12'h084, 32'd3);

    // R7 / R5 completion
    @(negedge clk); done_valid = 1'b1; done_id = 5'd0;
    @(negedge clk); done_valid = 1'b0;
    rd(12'h428, v, vb); chk("R7 done bit0", v, 32'd1);
    rd(12'h084, v, vb); chk("R5 eot pending", v, 32'd2);
    #1 chk("R6 irq on eot", {31'd0, irq}, 32'd1);
    wr(12'h084, 32'd2);

    // R8 flush and disabled start
    wr(12'h400, 32'd0);
    #1 chk("R8 flushed valid", {31'd0, dvalid}, 32'd0);
    rd(12'h408, v, vb); chk("R8 start after flush", v, 32'd0);
    wr(12'h408, 32'd1);
    rd(12'h404, v, vb); chk("R8 disabled start ignored", v, 32'd4);

    // R2 wrap and R7 clear on reuse
    wr(12'h400, 32'd1);
    @(negedge clk); desc_ready = 1'b1;
    for (int k = 0; k < 12; k++) wr(12'h408, 32'd1);
    rd(12'h404, v, vb); chk("R2 wrap to 0", v, 32'd0);
    rd(12'h428, v, vb); chk("R7 bit held", v, 32'd1);
    wr(12'h408, 32'd1);
    rd(12'h404, v, vb); chk("R2 after wrap", v, 32'd1);
    rd(12'h428, v, vb); chk("R7 reuse clears", v, 32'd0);
    @(negedge clk); desc_ready = 1'b0;

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule